// File: doc/BRIEF.md
# Tone-Present Detect Qualifier

This block takes two raw tone-energy indications, one from a call-progress tone detector and one from a special (fax) tone detector. It debounces each one in time and drives a clean detect level for each. Each raw input is sampled only on a millisecond tick that comes from the master clock. A channel turns on after an unbroken run of tone-present ticks. Once on, it turns off only after an unbroken run of tone-absent ticks. Short bursts and short dropouts therefore do not change the outputs.

A master enable clears both channels. Call-progress detection has priority, so the fax output is held low while the call-progress output is high. A single-clock pulse marks each new call-progress detection and is meant to set a sticky status flag elsewhere. The default windows are 50 ticks for presence and 50 ticks for absence. With a 1 ms tick, a tone that lasts 70 ms is always accepted, a 35 ms burst is always rejected, and the output is held for about 50 ms after the tone ends.

Top module: `tone_qualifier`

## Requirements
- R1: Each channel's state goes from off to on on the ms_tick on which its raw input has been 1 for ON_MS consecutive ticks, counting that tick. It does not go on at any earlier tick.
- R2: A run of present ticks that is shorter than ON_MS, or that is broken by one absent tick, does not turn the channel on. The run count starts again from zero after the break.
- R3: An on channel goes off on the ms_tick on which its raw input has been 0 for OFF_MS consecutive ticks. Any present tick inside a gap restarts that gap count.
- R4: Raw inputs are looked at only in clock cycles where ms_tick is 1. Changes in other cycles have no effect.
- R5: While det_en is 0, cp_det and fx_det are 0 in the same cycle. Both channel states and both counters are cleared, so after det_en returns to 1 a full ON_MS run is needed again.
- R6: fx_det is 0 whenever cp_det is 1. Otherwise fx_det follows the fax channel state.
- R7: cp_rise is 1 for exactly one clock, in the first cycle in which cp_det is 1 after being 0. It never pulses for fax-channel activity.
- R8: After an active-low rst_n, cp_det, fx_det and cp_rise are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-clock sampling strobe (nominally 1 ms) |
| det_en | input | 1 | Detection enable; 0 clears and holds both outputs low |
| cp_raw | input | 1 | Raw call-progress tone-present indication |
| fx_raw | input | 1 | Raw fax tone-present indication |
| cp_det | output | 1 | Qualified call-progress detect |
| fx_det | output | 1 | Qualified fax detect (suppressed while cp_det is 1) |
| cp_rise | output | 1 | One-clock pulse on a new call-progress detection |

## Verification
The bench sweeps the length of a present burst from one tick to past the on-threshold, and follows each burst with an absent run. This checks the exact tick of assertion against the exact tick of release, and shows that bursts just under the threshold leave no trace. Two further patterns separate a true run counter from an accumulating one: a burst broken by a single absent tick, and a held output with a single present tick inside its gap. Raw-input changes between ticks, overlapping call-progress and fax tones, and disabling while both are on show that the tick gates sampling, that fax is suppressed while call-progress is on, and that disabling clears the accumulated state.

// File: rtl/tone_qualifier.sv
module tone_qualifier #(
  parameter int ON_MS  = 50,
  parameter int OFF_MS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic det_en,
  input  logic cp_raw,
  input  logic fx_raw,
  output logic cp_det,
  output logic fx_det,
  output logic cp_rise
);
  localparam int LIM = (ON_MS > OFF_MS) ? ON_MS : OFF_MS;
  localparam int CW  = $clog2(LIM + 1);
  localparam logic [CW-1:0] ON_END  = CW'(ON_MS - 1);
  localparam logic [CW-1:0] OFF_END = CW'(OFF_MS - 1);
  localparam logic [CW-1:0] CMAX    = CW'(LIM - 1);

  logic [1:0]    raw;
  logic [1:0]    st;
  logic [CW-1:0] cnt [2];

  assign raw = {fx_raw, cp_raw};

  for (genvar i = 0; i < 2; i++) begin : g_ch
    logic [CW-1:0] lim_end;
    assign lim_end = st[i] ? OFF_END : ON_END;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st[i]  <= 1'b0;
        cnt[i] <= '0;
      end else if (!det_en) begin
        st[i]  <= 1'b0;
        cnt[i] <= '0;
      end else if (ms_tick) begin
        if (raw[i] != st[i]) begin
          if (cnt[i] == lim_end) begin
            st[i]  <= ~st[i];
            cnt[i] <= '0;
          end else begin
            cnt[i] <= cnt[i] + 1'b1;
          end
        end else begin
          cnt[i] <= '0;
        end
      end
    end

    // R1
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[i] <= CMAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cp_rise <= 1'b0;
    else        cp_rise <= det_en && ms_tick && cp_raw && !st[0] && (cnt[0] == ON_END);
  end

  assign cp_det = st[0] & det_en;
  assign fx_det = st[1] & det_en & ~cp_det;

  // R7
  rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cp_rise |-> (st[0] && !$past(st[0])));
  // R6
  fx_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cp_det |-> !fx_det);
  // R5
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> (st == 2'b00));
  // R4
  cp_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[0]) |-> $past(ms_tick && cp_raw));
  // R3
  cp_off_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st[0]) |-> ($past(ms_tick && !cp_raw) || $past(!det_en)));
  // R4
  fx_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[1]) |-> $past(ms_tick && fx_raw));
endmodule

// File: tb/tone_qualifier_test.sv
module tone_qualifier_test;
  localparam int ON  = 5;
  localparam int OFF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0, det_en = 1'b1, cp_raw = 1'b0, fx_raw = 1'b0;
  logic cp_det, fx_det, cp_rise;
  int   vec = 0, err = 0;

  always #10 clk = ~clk;

  tone_qualifier #(.ON_MS(ON), .OFF_MS(OFF)) uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .det_en(det_en),
    .cp_raw(cp_raw), .fx_raw(fx_raw),
    .cp_det(cp_det), .fx_det(fx_det), .cp_rise(cp_rise));

  task automatic chk(input string req, input logic act, input logic exp);
    vec++;
    if (act !== exp) begin
      err++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic tk(input logic c, input logic f);
    @(negedge clk);
    cp_raw = c; fx_raw = f; ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    err++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8
    chk("R8 cp_det", cp_det, 1'b0);
    chk("R8 fx_det", fx_det, 1'b0);
    chk("R8 cp_rise", cp_rise, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 R7 sweep of burst length
    for (int L = 1; L <= ON + 2; L++) begin
      for (int k = 1; k <= L; k++) begin
        tk(1'b1, 1'b0);
        chk("R1", cp_det, k >= ON);
        chk("R7", cp_rise, k == ON);
        chk("R6", fx_det, 1'b0);
      end
      for (int j = 1; j <= OFF; j++) begin
        tk(1'b0, 1'b0);
        chk("R3", cp_det, (L >= ON) && (j < OFF));
        chk("R7", cp_rise, 1'b0);
      end
    end

    // R2 broken burst
    for (int k = 1; k < ON; k++) begin tk(1'b1, 1'b0); chk("R2", cp_det, 1'b0); end
    tk(1'b0, 1'b0); chk("R2", cp_det, 1'b0);
    for (int k = 1; k < ON; k++) begin tk(1'b1, 1'b0); chk("R2", cp_det, 1'b0); end
    tk(1'b0, 1'b0);

    // R3 gap restart
    for (int k = 1; k <= ON; k++) tk(1'b1, 1'b0);
    chk("R1", cp_det, 1'b1);
    for (int j = 1; j < OFF; j++) begin tk(1'b0, 1'b0); chk("R3", cp_det, 1'b1); end
    tk(1'b1, 1'b0); chk("R3", cp_det, 1'b1);
    for (int j = 1; j < OFF; j++) begin tk(1'b0, 1'b0); chk("R3", cp_det, 1'b1); end
    // R4 no tick: raw change ignored while on
    @(negedge clk); cp_raw = 1'b0;
    repeat (3 * OFF) @(negedge clk);
    chk("R4", cp_det, 1'b1);
    tk(1'b0, 1'b0); chk("R3", cp_det, 1'b0);

    // R4 no tick: presence ignored while off
    @(negedge clk); cp_raw = 1'b1; fx_raw = 1'b1;
    repeat (3 * ON) @(negedge clk);
    chk("R4", cp_det, 1'b0);
    chk("R4", fx_det, 1'b0);
    for (int k = 1; k < ON; k++) begin tk(1'b0, 1'b0); end

    // R1 R3 fax channel
    for (int k = 1; k <= ON; k++) begin
      tk(1'b0, 1'b1);
      chk("R1 fx", fx_det, k >= ON);
      chk("R7 fx", cp_rise, 1'b0);
    end
    // R6 cp overrides fax
    for (int k = 1; k <= ON; k++) begin
      tk(1'b1, 1'b1);
      chk("R6", fx_det, k < ON);
      chk("R1", cp_det, k >= ON);
    end
    for (int j = 1; j <= OFF; j++) begin
      tk(1'b0, 1'b1);
      chk("R6", fx_det, j >= OFF);
      chk("R3", cp_det, j < OFF);
    end

    // R5 enable
    for (int k = 1; k <= ON; k++) tk(1'b1, 1'b1);
    chk("R5 pre", cp_det, 1'b1);
    @(negedge clk); det_en = 1'b0;
    #1;
    chk("R5", cp_det, 1'b0);
    chk("R5", fx_det, 1'b0);
    for (int k = 1; k <= 3; k++) begin
      tk(1'b1, 1'b1);
      chk("R5", cp_det, 1'b0);
      chk("R5", fx_det, 1'b0);
      chk("R5", cp_rise, 1'b0);
    end
    @(negedge clk); det_en = 1'b1;
    #1;
    chk("R5", cp_det, 1'b0);
    for (int k = 1; k <= ON; k++) begin
      tk(1'b1, 1'b1);
      chk("R5", cp_det, k >= ON);
      chk("R7", cp_rise, k == ON);
    end
    @(negedge clk);
    chk("R7 width", cp_rise, 1'b0);
    chk("R6", fx_det, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
    $finish;
  end
endmodule